// File: doc/BRIEF.md
# Comparator Output Digital Conditioner

This block takes the one-bit result of an analog comparator, which arrives with no relation to the system clock, and turns it into clean digital information. The bit passes through a synchronizer chain. It can be inverted when the comparator's inputs are exchanged, and it then feeds a short history register that can vote by majority to reject glitches. The block reports a filtered state, a ready flag and a one-cycle interrupt pulse. It also gives an optional event pulse and a pin value whose source is selectable.

In continuous mode the filtered state follows the input on every clock. In single-shot mode the block stays idle until it receives a start strobe or an enabled event. It then collects exactly the number of samples that the chosen filter needs, latches the vote, raises ready and returns to idle. Clearing the enable puts the whole block back to its empty state.

Top module: `cmp_conditioner`

## Requirements
- R1: After reset, state_o, ready_o, irq_o, evt_o and pin_o are all 0.
- R2: raw_in passes through a two-flop synchronizer. When swap_en is 1, the synchronized bit is inverted before it reaches the history register.
- R3: filt_sel selects the vote. Codes 0 and 3 use the newest sample only, code 1 takes a 2-of-3 majority of the three newest samples and code 2 takes a 3-of-5 majority of the five newest.
- R4: While cmp_en is 0, the history, the sample count, state_o and ready_o are cleared, and at the next edge irq_o and evt_o are 0.
- R5: In continuous mode (single_mode=0), ready_o rises once the history holds as many samples as the vote needs (1, 3 or 5) since enable. From that point state_o takes the vote on every clock.
- R6: irq_sel chooses what triggers irq_o, a one-cycle pulse issued in the same cycle that state_o shows the new value. Code 0 fires on any change of the state, code 1 on a change to 1 and code 2 on a change to 0.
- R7: irq_sel code 3 fires irq_o at the end of each single-shot comparison, whatever the result. In continuous mode it never fires.
- R8: In single-shot mode an idle block starts a comparison when start_i=1, or when evt_i=1 and evt_in_en=1. evt_i alone is ignored when evt_in_en=0. Triggers that arrive during a comparison are ignored.
- R9: A single-shot comparison clears the history and collects N samples (N = 1, 3 or 5). On the following edge it latches the vote into state_o and sets ready_o. ready_o clears when the next comparison starts.
- R10: evt_o pulses under the same condition as irq_o, but only when evt_out_en=1.
- R11: route_sel selects pin_o. Codes 0 and 3 give 0. Code 1 gives raw_in XOR swap_en with no clocking. Code 2 gives state_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Asynchronous comparator result |
| cmp_en | input | 1 | Comparator enable |
| single_mode | input | 1 | 1 = single-shot, 0 = continuous |
| swap_en | input | 1 | Inverts the result (inputs exchanged) |
| filt_sel | input | 2 | Filter select code |
| irq_sel | input | 2 | Interrupt trigger select code |
| route_sel | input | 2 | Pin source select code |
| evt_in_en | input | 1 | Lets evt_i start a comparison |
| evt_out_en | input | 1 | Enables evt_o |
| start_i | input | 1 | Single-shot start strobe |
| evt_i | input | 1 | Incoming event |
| state_o | output | 1 | Filtered comparator state |
| ready_o | output | 1 | Result valid |
| irq_o | output | 1 | Interrupt pulse |
| evt_o | output | 1 | Event pulse |
| pin_o | output | 1 | Routed pin value |

## Verification
The assertions assume that the mode, filter and trigger selections stay fixed while cmp_en is 1. In particular, a pulse on irq_o is judged against the irq_sel and single_mode values that held one cycle earlier. The stimulus respects this by changing configuration only while the comparator is disabled, and it holds the block disabled for a few cycles between scenarios. Within a scenario, raw_in flips with low probability so that edges stay sparse enough to pass the filters. Start and event strobes arrive at random, including during a comparison that is already running.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
   typedef enum logic [1:0] {
      FILT_NONE = 2'd0,
      FILT_MAJ3 = 2'd1,
      FILT_MAJ5 = 2'd2,
      FILT_RSVD = 2'd3
   } filt_e;

   typedef enum logic [1:0] {
      IRQ_TOGGLE = 2'd0,
      IRQ_RISE   = 2'd1,
      IRQ_FALL   = 2'd2,
      IRQ_EOC    = 2'd3
   } irq_e;

   typedef enum logic [1:0] {
      ROUTE_OFF  = 2'd0,
      ROUTE_RAW  = 2'd1,
      ROUTE_FILT = 2'd2,
      ROUTE_RSVD = 2'd3
   } route_e;

   typedef enum logic {
      SS_IDLE = 1'b0,
      SS_BUSY = 1'b1
   } phase_e;

   // Number of samples the selected vote needs.
   function automatic logic [2:0] taps_of(filt_e f);
      case (f)
         FILT_MAJ3: taps_of = 3'd3;
         FILT_MAJ5: taps_of = 3'd5;
         default:   taps_of = 3'd1;
      endcase
   endfunction
endpackage

// File: rtl/ccd_sync.sv
module ccd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ccd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ccd_filter.sv
module ccd_filter #(
   parameter int HIST_W = 5,
   localparam int CNT_W = $clog2(HIST_W + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       shift_i,
   input  logic       din_i,
   input  logic [2:0] taps_i,
   output logic       vote_o,
   output logic       full_o
);
   if (HIST_W < 5) begin : g_bad_hist
      $error("ccd_filter: HIST_W must hold at least five samples");
   end

   logic [HIST_W-1:0] hist_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [HIST_W-1:0] mask;
   int                ones;
   int                taps_n;

   assign taps_n = int'(taps_i);

   always_comb begin
      mask = '0;
      for (int i = 0; i < HIST_W; i++) begin
         if (i < taps_n) mask[i] = 1'b1;
      end
      ones = $countones(hist_q & mask);
   end

   assign vote_o = (2 * ones) > taps_n;
   assign full_o = int'(cnt_q) >= taps_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         cnt_q  <= '0;
      end else if (clr_i) begin
         hist_q <= '0;
         cnt_q  <= '0;
      end else if (shift_i) begin
         hist_q <= {hist_q[HIST_W-2:0], din_i};
         if (!full_o) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ccd_ctrl.sv
module ccd_ctrl
   import ccd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_en,
   input  logic single_mode,
   input  irq_e irq_sel,
   input  logic evt_in_en,
   input  logic evt_out_en,
   input  logic start_i,
   input  logic evt_i,
   input  logic vote_i,
   input  logic full_i,
   output logic filt_clr_o,
   output logic filt_shift_o,
   output logic state_o,
   output logic ready_o,
   output logic irq_o,
   output logic evt_o
);
   phase_e ph_q, ph_nxt;
   logic   st_q, done_q, irq_q, evt_q;
   logic   trig, update, chg, hit;

   assign trig = start_i | (evt_in_en & evt_i);

   always_comb begin
      filt_clr_o   = 1'b0;
      filt_shift_o = 1'b0;
      update       = 1'b0;
      ph_nxt       = ph_q;
      if (!cmp_en) begin
         filt_clr_o = 1'b1;
         ph_nxt     = SS_IDLE;
      end else if (!single_mode) begin
         filt_shift_o = 1'b1;
         update       = full_i;
      end else if (ph_q == SS_IDLE) begin
         if (trig) begin
            filt_clr_o = 1'b1;
            ph_nxt     = SS_BUSY;
         end
      end else begin
         if (full_i) begin
            update = 1'b1;
            ph_nxt = SS_IDLE;
         end else begin
            filt_shift_o = 1'b1;
         end
      end
   end

   assign chg = update && (vote_i != st_q);

   always_comb begin
      case (irq_sel)
         IRQ_TOGGLE: hit = chg;
         IRQ_RISE:   hit = chg & vote_i;
         IRQ_FALL:   hit = chg & ~vote_i;
         default:    hit = single_mode & update;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= SS_IDLE;
         st_q   <= 1'b0;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
         evt_q  <= 1'b0;
      end else if (!cmp_en) begin
         ph_q   <= SS_IDLE;
         st_q   <= 1'b0;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         ph_q  <= ph_nxt;
         irq_q <= hit;
         evt_q <= hit & evt_out_en;
         if (update) st_q <= vote_i;
         if (single_mode && ph_q == SS_IDLE && trig) done_q <= 1'b0;
         else if (single_mode && update)             done_q <= 1'b1;
      end
   end

   assign state_o = st_q;
   assign ready_o = cmp_en & (single_mode ? done_q : full_i);
   assign irq_o   = irq_q;
   assign evt_o   = evt_q;
endmodule

// File: rtl/cmp_conditioner.sv
module cmp_conditioner
   import ccd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HIST_W      = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw_in,
   input  logic       cmp_en,
   input  logic       single_mode,
   input  logic       swap_en,
   input  logic [1:0] filt_sel,
   input  logic [1:0] irq_sel,
   input  logic [1:0] route_sel,
   input  logic       evt_in_en,
   input  logic       evt_out_en,
   input  logic       start_i,
   input  logic       evt_i,
   output logic       state_o,
   output logic       ready_o,
   output logic       irq_o,
   output logic       evt_o,
   output logic       pin_o
);
   logic       sync_bit, samp_bit, vote, full, fclr, fshift;
   logic [2:0] taps;

   ccd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_bit)
   );

   assign samp_bit = sync_bit ^ swap_en;
   assign taps     = taps_of(filt_e'(filt_sel));

   ccd_filter #(.HIST_W(HIST_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .clr_i(fclr), .shift_i(fshift),
      .din_i(samp_bit), .taps_i(taps), .vote_o(vote), .full_o(full)
   );

   ccd_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .single_mode(single_mode),
      .irq_sel(irq_e'(irq_sel)), .evt_in_en(evt_in_en), .evt_out_en(evt_out_en),
      .start_i(start_i), .evt_i(evt_i), .vote_i(vote), .full_i(full),
      .filt_clr_o(fclr), .filt_shift_o(fshift), .state_o(state_o),
      .ready_o(ready_o), .irq_o(irq_o), .evt_o(evt_o)
   );

   always_comb begin
      case (route_e'(route_sel))
         ROUTE_RAW:  pin_o = raw_in ^ swap_en;
         ROUTE_FILT: pin_o = state_o;
         default:    pin_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/ccd_checker.sv
module ccd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmp_en,
   input logic       single_mode,
   input logic [1:0] irq_sel,
   input logic       evt_out_en,
   input logic       state_o,
   input logic       ready_o,
   input logic       irq_o,
   input logic       evt_o
);
   // R4
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en |=> (!irq_o && !evt_o && !state_o && !ready_o));

   // R6
   rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $past(irq_sel) == 2'd1 && $past(cmp_en)) |-> $rose(state_o));

   // R6
   fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $past(irq_sel) == 2'd2 && $past(cmp_en)) |-> $fell(state_o));

   // R7
   no_eoc_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sel == 2'd3 && !single_mode) |=> !irq_o);

   // R10
   evt_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> (irq_o && $past(evt_out_en)));

   // R9
   shot_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (single_mode && $past(single_mode) && cmp_en && $past(cmp_en)
       && !$stable(state_o)) |-> ready_o);
endmodule

bind cmp_conditioner ccd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .single_mode(single_mode),
   .irq_sel(irq_sel), .evt_out_en(evt_out_en), .state_o(state_o),
   .ready_o(ready_o), .irq_o(irq_o), .evt_o(evt_o)
);

// File: tb/sim_cmp_conditioner.sv
`timescale 1ns/1ps
module sim_cmp_conditioner;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic raw_in = 0, cmp_en = 0, single_mode = 0, swap_en = 0;
   logic [1:0] filt_sel = 0, irq_sel = 0, route_sel = 0;
   logic evt_in_en = 0, evt_out_en = 0, start_i = 0, evt_i = 0;
   logic state_o, ready_o, irq_o, evt_o, pin_o;

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   cmp_conditioner u0 (.*);

   // Reference model state
   logic m_s1, m_s2, m_st, m_irq, m_evt, m_busy, m_done;
   logic [4:0] m_hist;
   int m_cnt;

   function automatic int taps_f(logic [1:0] f);
      return (f == 2'd1) ? 3 : (f == 2'd2) ? 5 : 1;
   endfunction

   function automatic logic vote_f(logic [4:0] h, int t);
      int ones = 0;
      for (int i = 0; i < t; i++) ones += int'(h[i]);
      return (2 * ones) > t;
   endfunction

   function automatic logic exp_ready();
      return cmp_en & (single_mode ? m_done : (m_cnt >= taps_f(filt_sel)));
   endfunction

   function automatic logic exp_pin();
      case (route_sel)
         2'd1: return raw_in ^ swap_en;
         2'd2: return m_st;
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 0; m_s2 <= 0; m_st <= 0; m_irq <= 0; m_evt <= 0;
         m_busy <= 0; m_done <= 0; m_hist <= 0; m_cnt <= 0;
      end else begin
         logic upd, nv, hit, samp, trig;
         int t;
         t = taps_f(filt_sel);
         samp = m_s2 ^ swap_en;
         trig = start_i | (evt_in_en & evt_i);
         upd = 0;
         nv = vote_f(m_hist, t);
         m_s1 <= raw_in;
         m_s2 <= m_s1;
         if (!cmp_en) begin
            m_st <= 0; m_irq <= 0; m_evt <= 0; m_busy <= 0; m_done <= 0;
            m_hist <= 0; m_cnt <= 0;
         end else begin
            if (!single_mode) begin
               upd = (m_cnt >= t);
               m_hist <= {m_hist[3:0], samp};
               if (m_cnt < t) m_cnt <= m_cnt + 1;
            end else if (!m_busy) begin
               if (trig) begin
                  m_busy <= 1; m_done <= 0; m_hist <= 0; m_cnt <= 0;
               end
            end else if (m_cnt >= t) begin
               upd = 1; m_busy <= 0; m_done <= 1;
            end else begin
               m_hist <= {m_hist[3:0], samp};
               m_cnt <= m_cnt + 1;
            end
            case (irq_sel)
               2'd0: hit = upd && (nv != m_st);
               2'd1: hit = upd && (nv != m_st) && nv;
               2'd2: hit = upd && (nv != m_st) && !nv;
               default: hit = single_mode && upd;
            endcase
            if (upd) m_st <= nv;
            m_irq <= hit;
            m_evt <= hit & evt_out_en;
         end
      end
   end

   task automatic chk(string req, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // Compare all outputs against the model (called at negedge)
   task automatic chk_all();
      chk("R3 state", state_o, m_st);
      chk("R6 irq", irq_o, m_irq);
      chk("R10 evt", evt_o, m_evt);
      chk("R5/R9 ready", ready_o, exp_ready());
      chk("R11 pin", pin_o, exp_pin());
   endtask

   task automatic step_checked();
      @(negedge clk);
      chk_all();
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 state", state_o, 0); chk("R1 ready", ready_o, 0);
      chk("R1 irq", irq_o, 0); chk("R1 evt", evt_o, 0); chk("R1 pin", pin_o, 0);
      rst_n = 1;

      // R2 + R3: directed, continuous, no filter, swap: latency through sync
      cmp_en = 1; raw_in = 1; swap_en = 1; route_sel = 2;
      repeat (6) step_checked();
      chk("R2 swapped state", state_o, 1'b0);
      raw_in = 0;
      repeat (6) step_checked();
      chk("R2 swapped state low raw", state_o, 1'b1);

      // R3: 2-of-3 rejects one-cycle glitch
      @(negedge clk); cmp_en = 0; swap_en = 0; filt_sel = 1; raw_in = 1;
      step_checked(); cmp_en = 1;
      repeat (10) step_checked();
      raw_in = 0; step_checked(); raw_in = 1;
      begin
         logic seen_low = 0;
         repeat (8) begin step_checked(); if (!state_o) seen_low = 1; end
         chk("R3 glitch rejected", seen_low, 1'b0);
      end

      // R8: event ignored without evt_in_en
      @(negedge clk); cmp_en = 0; single_mode = 1; filt_sel = 0; irq_sel = 3;
      step_checked(); cmp_en = 1; evt_i = 1; step_checked(); evt_i = 0;
      repeat (6) step_checked();
      chk("R8 event ignored ready", ready_o, 1'b0);
      evt_in_en = 1; evt_i = 1; step_checked(); evt_i = 0;
      repeat (3) step_checked();
      chk("R8 event starts shot", ready_o, 1'b1);

      // R7: EOC select in continuous mode never fires
      @(negedge clk); cmp_en = 0; single_mode = 0; step_checked(); cmp_en = 1;
      begin
         logic seen = 0;
         for (int i = 0; i < 40; i++) begin
            raw_in = (i % 6) < 3;
            step_checked(); if (irq_o) seen = 1;
         end
         chk("R7 no EOC in continuous", seen, 1'b0);
      end

      // Random scenarios
      for (int s = 0; s < 60; s++) begin
         @(negedge clk);
         cmp_en = 0;
         single_mode = $urandom_range(0, 1); swap_en = $urandom_range(0, 1);
         filt_sel = 2'($urandom_range(0, 3)); irq_sel = 2'($urandom_range(0, 3));
         route_sel = 2'($urandom_range(0, 3));
         evt_in_en = $urandom_range(0, 1); evt_out_en = $urandom_range(0, 1);
         start_i = 0; evt_i = 0;
         // R4 disabled state
         repeat (3) begin
            step_checked();
            chk("R4 disabled state", state_o, 1'b0);
            chk("R4 disabled ready", ready_o, 1'b0);
         end
         cmp_en = 1;
         for (int c = 0; c < 80; c++) begin
            if ($urandom_range(0, 3) == 0) raw_in = ~raw_in;
            start_i = ($urandom_range(0, 9) == 0);
            evt_i   = ($urandom_range(0, 9) == 0);
            step_checked();
         end
         start_i = 0; evt_i = 0;
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule